// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host side of a single-wire, open-drain background debug link. It sends command bytes to a target and reads reply bytes back. Every bit, in either direction, opens with a low that the host drives. A transmitted 1 is a short low and a transmitted 0 is a long low, and each is followed by a one-tick driven-high speedup pulse. To receive a bit, the host drives a short start low and then releases the line. The target either lets the line rise or holds it low, and the host samples the synchronized line partway through the slot.

Software, or a rate-discovery block, programs one number: the count of system ticks that covers 16 target clock cycles. A start strobe captures that count together with a transmit byte count and a receive byte count. The engine pulls transmit bytes from a stream and returns each received byte with a strobe. The low widths, the speedup position and the sample point all come from the captured tick count. Transceiver direction is controlled by a drive-enable output, and the line idles released.

Top module: `sdbg_host_engine`

## Requirements
- R1: Out of reset, and whenever no transfer is running, `drive_en_o`, `speedup_o`, `busy_o` and `done_o` are 0, so the line is left to its pull-up.
- R2: A bit slot lasts exactly P system ticks, where P is `period_i` captured at start. Every slot opens with the host driving low in its first tick. Slots follow one another with no gap, and each byte goes out or comes in most significant bit first.
- R3: A transmitted 1 drives low for round(P/4) ticks. In the next tick, `speedup_o` and `pin_o` are 1 with `drive_en_o` high for exactly one tick, and after that the line is released.
- R4: A transmitted 0 drives low for round(13P/16) ticks, followed by the same single-tick speedup.
- R5: A receive slot drives a start low of round(P/4) ticks and then releases the line. `speedup_o` is never 1 during a receive slot.
- R6: The pin passes through a two-flop synchronizer. The engine samples the line level present round(10P/16) ticks after the slot's falling edge: low reads as 0, high reads as 1. When a byte's eighth slot ends, `rx_valid_o` pulses for one cycle with the byte on `rx_data_o`.
- R7: All transmit bytes are sent before any receive byte. A byte is taken from `tx_data_i` when start is accepted and at each transmit byte boundary. `tx_pop_o` pulses in the cycle after each take, and `tx_data_i` must then show the next byte.
- R8: `busy_o` rises in the cycle after start is accepted and stays high through the last slot. `done_o` pulses for one cycle in the cycle after the last slot ends. When both counts are zero, `done_o` pulses in the cycle after start and `busy_o` stays 0.
- R9: A start strobe while `busy_o` is high is ignored. The running transfer keeps its byte counts and timing.
- R10: `period_i` must be at least 16 when start is accepted. Changes to `period_i` during a transfer have no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | TICK_W | System ticks per 16 target clock cycles |
| start_i | input | 1 | Start strobe, accepted only when idle |
| tx_count_i | input | CNT_W | Number of bytes to transmit |
| rx_count_i | input | CNT_W | Number of bytes to receive |
| tx_data_i | input | 8 | Current byte of the transmit stream |
| tx_pop_o | output | 1 | A transmit byte was taken; present the next one |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |
| pin_i | input | 1 | Line level from the transceiver |
| pin_o | output | 1 | Level driven on the line when enabled |
| drive_en_o | output | 1 | Transceiver direction: 1 drives the line |
| speedup_o | output | 1 | Driven-high speedup tick |

## Verification
The assertions assume that a start is only accepted with a period of at least 16 ticks. Under that assumption, every low width plus its speedup tick fits inside the slot, and the sample point falls between the short and long lows. The stimulus picks periods from 16 to 40, including odd values where the rounding matters. It plays a target model that holds the line low for round(13P/16) ticks on reply 0 bits and never drives during transmit slots, so no contention arises that the engine could not see. Start strobes sent during a busy transfer and period changes made mid-transfer are directed cases.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_e;
  localparam int SYNC_STAGES = 2;
  localparam int MIN_PERIOD  = 16;
  localparam int BYTE_W      = 8;
endpackage

// File: rtl/sdbg_sync2.sv
module sdbg_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sdbg_timing.sv
module sdbg_timing import sdbg_pkg::*; #(
  parameter int TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TICK_W-1:0] period_i,
  output logic [TICK_W-1:0] period_o,
  output logic [TICK_W-1:0] w1_o,
  output logic [TICK_W-1:0] w0_o,
  output logic [TICK_W-1:0] samp_o
);
  localparam int EXT_W = TICK_W + 4;

  logic [EXT_W-1:0]  p_ext;
  logic [TICK_W-1:0] w1_d, w0_d, thr_d;

  // round(k*P/16) = (k*P + 8) >> 4
  assign p_ext = EXT_W'(period_i);
  assign w1_d  = TICK_W'(((p_ext << 2) + EXT_W'(8)) >> 4);
  assign w0_d  = TICK_W'(((p_ext << 3) + (p_ext << 2) + p_ext + EXT_W'(8)) >> 4);
  assign thr_d = TICK_W'(((p_ext << 3) + (p_ext << 1) + EXT_W'(8)) >> 4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= TICK_W'(MIN_PERIOD);
      w1_o     <= '0;
      w0_o     <= '0;
      samp_o   <= '0;
    end else if (load_i) begin
      period_o <= period_i;
      w1_o     <= w1_d;
      w0_o     <= w0_d;
      samp_o   <= thr_d + TICK_W'(SYNC_STAGES); // cover synchronizer latency
    end
  end

  assert_period_min_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> period_i >= TICK_W'(MIN_PERIOD));
endmodule

// File: rtl/sdbg_slot_gen.sv
module sdbg_slot_gen #(
  parameter int TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              is_tx_i,
  input  logic              bit_i,
  input  logic [TICK_W-1:0] period_i,
  input  logic [TICK_W-1:0] w1_i,
  input  logic [TICK_W-1:0] w0_i,
  input  logic [TICK_W-1:0] samp_i,
  output logic              slot_end_o,
  output logic              samp_o,
  output logic              drive_en_o,
  output logic              pin_o,
  output logic              speedup_o
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] low_w;
  logic              host_low, spd;

  assign slot_end_o = run_i && (cnt_q == period_i - TICK_W'(1));
  assign samp_o     = run_i && !is_tx_i && (cnt_q == samp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || slot_end_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + TICK_W'(1);
  end

  assign low_w      = (is_tx_i && !bit_i) ? w0_i : w1_i;
  assign host_low   = run_i && (cnt_q < low_w);
  assign spd        = run_i && is_tx_i && (cnt_q == low_w);
  assign drive_en_o = host_low || spd;
  assign pin_o      = spd;
  assign speedup_o  = spd;

  assert_no_rx_speedup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speedup_o |-> is_tx_i);
  assert_speedup_one_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speedup_o |=> !speedup_o);
  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !drive_en_o);
  assert_slot_opens_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_o && $past(run_i)) |=> (run_i -> (drive_en_o && !pin_o)));
endmodule

// File: rtl/sdbg_host_engine.sv
module sdbg_host_engine import sdbg_pkg::*; #(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TICK_W-1:0] period_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_pop_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              drive_en_o,
  output logic              speedup_o
);
  localparam int IDX_W = $clog2(BYTE_W);

  phase_e            phase_q;
  logic [IDX_W-1:0]  bit_idx_q;
  logic [CNT_W-1:0]  tx_left_q, rx_left_q;
  logic [7:0]        tx_sh_q, rx_sh_q, rx_data_q;
  logic              rx_valid_q, done_q, pop_q;
  logic              accept, pin_s, slot_end, samp;
  logic [TICK_W-1:0] per_w, w1_w, w0_w, samp_w;

  assign accept = start_i && (phase_q == PH_IDLE);

  sdbg_sync2 u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  sdbg_timing #(.TICK_W(TICK_W)) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .period_i(period_i),
    .period_o(per_w), .w1_o(w1_w), .w0_o(w0_w), .samp_o(samp_w)
  );

  sdbg_slot_gen #(.TICK_W(TICK_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(phase_q != PH_IDLE), .is_tx_i(phase_q == PH_TX), .bit_i(tx_sh_q[7]),
    .period_i(per_w), .w1_i(w1_w), .w0_i(w0_w), .samp_i(samp_w),
    .slot_end_o(slot_end), .samp_o(samp),
    .drive_en_o(drive_en_o), .pin_o(pin_o), .speedup_o(speedup_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_idx_q  <= '0;
      tx_left_q  <= '0;
      rx_left_q  <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      done_q     <= 1'b0;
      pop_q      <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      done_q     <= 1'b0;
      pop_q      <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          bit_idx_q <= IDX_W'(BYTE_W - 1);
          rx_left_q <= rx_count_i;
          if (tx_count_i != '0) begin
            phase_q   <= PH_TX;
            tx_sh_q   <= tx_data_i;
            tx_left_q <= tx_count_i - CNT_W'(1);
            pop_q     <= 1'b1;
          end else if (rx_count_i != '0) begin
            phase_q   <= PH_RX;
          end else begin
            done_q    <= 1'b1;
          end
        end
        PH_TX: if (slot_end) begin
          if (bit_idx_q != '0) begin
            bit_idx_q <= bit_idx_q - IDX_W'(1);
            tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
          end else begin
            bit_idx_q <= IDX_W'(BYTE_W - 1);
            if (tx_left_q != '0) begin
              tx_sh_q   <= tx_data_i;
              tx_left_q <= tx_left_q - CNT_W'(1);
              pop_q     <= 1'b1;
            end else if (rx_left_q != '0) begin
              phase_q   <= PH_RX;
            end else begin
              phase_q   <= PH_IDLE;
              done_q    <= 1'b1;
            end
          end
        end
        PH_RX: begin
          if (samp) rx_sh_q <= {rx_sh_q[6:0], pin_s};
          if (slot_end) begin
            if (bit_idx_q != '0) begin
              bit_idx_q <= bit_idx_q - IDX_W'(1);
            end else begin
              bit_idx_q  <= IDX_W'(BYTE_W - 1);
              rx_data_q  <= rx_sh_q;
              rx_valid_q <= 1'b1;
              rx_left_q  <= rx_left_q - CNT_W'(1);
              if (rx_left_q == CNT_W'(1)) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = done_q;
  assign tx_pop_o   = pop_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_needs_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_rx_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_pop_in_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> (busy_o && !rx_valid_o));
endmodule

// File: tb/sdbg_host_engine_tb.sv
module sdbg_host_engine_tb;
  localparam int TICK_W = 16;
  localparam int CNT_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [TICK_W-1:0] period_i = 16'd16;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  tx_count_i = '0;
  logic [CNT_W-1:0]  rx_count_i = '0;
  logic [7:0]        tx_data_i;
  logic              tx_pop_o, rx_valid_o, busy_o, done_o;
  logic [7:0]        rx_data_o;
  logic              pin_drv = 1'b1;
  logic              pin_o, drive_en_o, speedup_o;

  always #2.5 clk_i = ~clk_i;

  sdbg_host_engine #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .start_i(start_i),
    .tx_count_i(tx_count_i), .rx_count_i(rx_count_i), .tx_data_i(tx_data_i),
    .tx_pop_o(tx_pop_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .busy_o(busy_o), .done_o(done_o), .pin_i(pin_drv), .pin_o(pin_o),
    .drive_en_o(drive_en_o), .speedup_o(speedup_o)
  );

  int n_chk = 0, n_fail = 0;
  int p_cur, ntx, nrx, pop_idx;
  logic [7:0] txq [8];
  logic [7:0] rxq [8];
  bit   mon_on = 0, prev_low = 0;
  int   slot_idx, tick, low_len, spd_cnt, spd_at, rx_got, pops, done_cnt, len_err;

  assign tx_data_i = txq[pop_idx & 7];

  function automatic int e_w1(int p); return (4*p + 8) / 16; endfunction
  function automatic int e_w0(int p); return (13*p + 8) / 16; endfunction

  function automatic void check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic bit slot_bit(int s);
    if (s < 8*ntx) return txq[s/8][7 - s%8];
    return rxq[(s - 8*ntx)/8][7 - (s - 8*ntx)%8];
  endfunction

  function automatic void finalize();
    int cur = slot_idx - 1;
    if (cur < 8*ntx) begin
      int exp = slot_bit(cur) ? e_w1(p_cur) : e_w0(p_cur);
      check(low_len == exp, slot_bit(cur) ? "R3 tx1 low width" : "R4 tx0 low width", low_len, exp);
      check(spd_cnt == 1 && spd_at == exp, "R3 speedup tick", spd_at, exp);
    end else begin
      check(low_len == e_w1(p_cur), "R5 rx start width", low_len, e_w1(p_cur));
      check(spd_cnt == 0, "R5 no speedup in rx", spd_cnt, 0);
    end
  endfunction

  // target model and protocol monitor, evaluated between clock edges
  always @(negedge clk_i) begin
    if (mon_on) begin
      bit host_low, tgt_low;
      host_low = drive_en_o && !pin_o;
      if (host_low && !prev_low) begin
        if (slot_idx > 0) begin
          if (tick != p_cur - 1) len_err++;
          check(tick == p_cur - 1, "R2 slot length", tick + 1, p_cur);
          finalize();
        end
        slot_idx++; tick = 0; low_len = 0; spd_cnt = 0; spd_at = -1;
      end else tick++;
      if (host_low) low_len++;
      if (speedup_o) begin
        spd_cnt++; spd_at = tick;
        check(drive_en_o && pin_o, "R3 speedup drives high", pin_o, 1);
      end
      tgt_low = (slot_idx > 0) && (slot_idx - 1 >= 8*ntx) && !slot_bit(slot_idx - 1)
                && (tick < e_w0(p_cur));
      pin_drv  = !(host_low || tgt_low);
      prev_low = host_low;
      if (tx_pop_o) begin pops++; pop_idx++; end
      if (rx_valid_o) begin
        check(rx_data_o == rxq[rx_got & 7], "R6 rx byte", rx_data_o, rxq[rx_got & 7]);
        rx_got++;
      end
      if (done_o) begin
        if (slot_idx > 0) begin
          finalize();
          if (tick != p_cur) len_err++;
          check(tick == p_cur, "R8 done after last slot", tick, p_cur);
        end
        done_cnt++;
      end
    end
  end

  task automatic run_xfer(int p, int nt, int nr, bit inject, bit chg_p);
    int wd = 0;
    @(negedge clk_i);
    p_cur = p; ntx = nt; nrx = nr; pop_idx = 0;
    slot_idx = 0; tick = 0; low_len = 0; spd_cnt = 0; spd_at = -1;
    rx_got = 0; pops = 0; done_cnt = 0; len_err = 0; prev_low = 0;
    mon_on = 1;
    period_i = TICK_W'(p); tx_count_i = CNT_W'(nt); rx_count_i = CNT_W'(nr);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == (nt + nr > 0), "R8 busy after start", busy_o, nt + nr > 0);
    if (nt + nr == 0) check(done_o == 1'b1, "R8 done on empty transfer", done_o, 1);
    if (chg_p) period_i = TICK_W'(p + 9);
    if (inject) begin
      repeat (20) @(negedge clk_i);
      tx_count_i = CNT_W'(3); rx_count_i = CNT_W'(3); start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (done_cnt == 0 && wd < 20000) begin @(negedge clk_i); wd++; end
    check(wd < 20000, "R8 watchdog", wd, 20000);
    @(negedge clk_i);
    check(done_cnt == 1, inject ? "R9 single done" : "R8 single done", done_cnt, 1);
    check(pops == nt, "R7 tx byte takes", pops, nt);
    check(rx_got == nr, inject ? "R9 rx byte count" : "R6 rx byte count", rx_got, nr);
    check(slot_idx == 8*(nt + nr), "R2 slot count", slot_idx, 8*(nt + nr));
    check(!drive_en_o && !busy_o && !speedup_o, "R1 released when idle", drive_en_o, 0);
    if (chg_p) check(len_err == 0, "R10 period held during transfer", len_err, 0);
    mon_on = 0;
    period_i = TICK_W'(p);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) begin txq[i] = 8'h00; rxq[i] = 8'h00; end
    #1;
    check(!drive_en_o && !busy_o && !speedup_o && !done_o, "R1 reset state", drive_en_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!drive_en_o && !busy_o, "R1 idle after reset", busy_o, 0);

    txq[0] = 8'hFF; txq[1] = 8'h00; rxq[0] = 8'h00; rxq[1] = 8'hFF;
    run_xfer(16, 2, 2, 0, 0);
    txq[0] = 8'hA5; rxq[0] = 8'h3C;
    run_xfer(22, 1, 1, 0, 0);
    run_xfer(17, 0, 0, 0, 0);
    rxq[0] = 8'h81; rxq[1] = 8'h7E;
    run_xfer(31, 0, 2, 0, 0);
    txq[0] = 8'h5A; txq[1] = 8'hC3; txq[2] = 8'h01;
    run_xfer(19, 3, 0, 0, 0);
    rxq[0] = 8'h96;
    run_xfer(24, 1, 1, 1, 0);
    run_xfer(20, 1, 1, 0, 1);

    for (int k = 0; k < 22; k++) begin
      int p  = 16 + $urandom_range(24);
      int nt = $urandom_range(3);
      int nr = $urandom_range(3);
      for (int i = 0; i < 8; i++) begin
        txq[i] = 8'($urandom); rxq[i] = 8'($urandom);
      end
      run_xfer(p, nt, nr, 0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R8 global watchdog actual=190000 expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule